// File: doc/BRIEF.md
# Serial Bus Status and Interrupt Flags

This block is the status register of a two-wire display-data serial controller. A byte-level shift engine sends it single-cycle event pulses. These mark a received byte (optionally tagged as an address phase), the hand-off of the transmit register to the output stage, an acknowledge sample and a clock event. From these pulses the block keeps eight status bits, holds the receive data byte, and drives one interrupt request.

The CPU sees the status byte on `status_o` and the receive data on `rx_data_o`. It pulses `rx_rd_i` when it reads the receive data and `tx_wr_i` when it writes new transmit data. It writes zeros through `reg_wr_i`/`reg_wdata_i` to acknowledge interrupt flags.

A received byte is accepted only while the receive buffer is empty; otherwise the byte is dropped. An address byte also updates the match and direction bits, using either a full 7-bit compare or a 4-bit group compare. When the module enable is low, the register is held at its reset value.

Top module: `serstat_top`

## Requirements
- R1: Status bit order, MSB to LSB: receive-interrupt (7), transmit-interrupt (6), match (5), direction (4), acknowledge (3), clock-interrupt (2), transmit-empty (1), receive-full (0). After reset, `status_o` is 8'h0A, `rx_data_o` is 0 and `irq_o` is 0.
- R2: With enable high, a received-byte pulse is accepted when receive-full is 0. In the next cycle, `rx_data_o` holds the byte and bits 7 and 0 are both 1.
- R3: A received-byte pulse that arrives while receive-full is 1 is dropped. `rx_data_o` and all status bits are unchanged by it.
- R4: An `rx_rd_i` pulse clears receive-full in the next cycle, unless a byte is accepted in that same cycle.
- R5: A transmit hand-off pulse sets bit 6 and bit 1. A `tx_wr_i` pulse clears bit 1, and a hand-off in the same cycle wins.
- R6: A register write clears bit 7, 6 or 2 where the written bit is 0. A written 1 leaves that bit as it was. A set event in the same cycle as a clear wins.
- R7: Bits 5, 4, 3, 1 and 0 ignore register writes.
- R8: An accepted byte tagged as an address, with the extended mode off, sets match when byte[7:1] equals `own_addr_i` and clears it otherwise. On a match, the direction bit takes byte[0]; otherwise the direction bit is unchanged.
- R9: With `ext_en_i` high, the address compare uses only byte[7:4] against `own_addr_i[6:3]`.
- R10: `irq_o` is 1 exactly when `ie_i` is 1 and at least one of bits 7, 6 or 2 is 1.
- R11: While `en_i` is 0, every event is ignored and `status_o` becomes 8'h0A from the next cycle on. `rx_data_o` is kept.
- R12: An acknowledge pulse loads bit 3 from `nak_i` (1 = no acknowledge). A clock-event pulse sets bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| ie_i | input | 1 | Interrupt enable |
| ext_en_i | input | 1 | Extended (4-bit group) address compare |
| own_addr_i | input | 7 | Programmed 7-bit address |
| rx_ev_i | input | 1 | Received-byte pulse |
| rx_is_addr_i | input | 1 | Received byte is an address phase |
| rx_byte_i | input | 8 | Received byte |
| tx_load_ev_i | input | 1 | Transmit register handed to output stage |
| ack_ev_i | input | 1 | Acknowledge sample pulse |
| nak_i | input | 1 | Sampled acknowledge level, 1 = not acknowledged |
| scl_ev_i | input | 1 | Clock event pulse |
| rx_rd_i | input | 1 | CPU read of receive data |
| tx_wr_i | input | 1 | CPU write of transmit data |
| reg_wr_i | input | 1 | CPU write of status register |
| reg_wdata_i | input | 8 | CPU write data |
| status_o | output | 8 | Status byte |
| rx_data_o | output | 8 | Receive data byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every event input is a one-cycle pulse sampled on the rising edge, and that `rx_is_addr_i` has meaning only together with `rx_ev_i`. They also assume that no input is unknown after reset. The stimulus drives all inputs on the falling edge and clears every pulse after one cycle. It draws each pulse with its own probability from a fixed seed, so that collisions (byte while full, set with clear, hand-off with CPU write) occur often. It keeps enable mostly high with short low stretches, and often forms address bytes from the programmed address so that both match outcomes are hit.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;
  localparam int EXT_W  = 4;

  localparam int B_RXIF  = 7;
  localparam int B_TXIF  = 6;
  localparam int B_MATCH = 5;
  localparam int B_SRW   = 4;
  localparam int B_RXAK  = 3;
  localparam int B_SCLIF = 2;
  localparam int B_TXBE  = 1;
  localparam int B_RXBF  = 0;

  localparam logic [DATA_W-1:0] STAT_RST = 8'h0A;

  // Address compare: full address, or upper group only in extended mode.
  function automatic logic addr_hit(input logic [DATA_W-1:0] b,
                                    input logic [ADDR_W-1:0] own,
                                    input logic ext);
    logic full_eq, grp_eq;
    full_eq = (b[DATA_W-1:1] == own);
    grp_eq  = (b[DATA_W-1:DATA_W-EXT_W] == own[ADDR_W-1:ADDR_W-EXT_W]);
    return ext ? grp_eq : full_eq;
  endfunction

  // Next value of a write-zero-to-clear flag; set has priority.
  function automatic logic wzc_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/serstat_wzc_flag.sv
module serstat_wzc_flag
  import serstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (!en) q <= 1'b0;
    else          q <= wzc_next(q, set, clr);
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && set) |=> q);
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr && !set) |=> !q);
  p_off_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !q);
endmodule

// File: rtl/serstat_rxbuf.sv
module serstat_rxbuf
  import serstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_ev,
  input  logic              rx_is_addr,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_rd,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ext_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rxbf,
  output logic              match,
  output logic              srw,
  output logic              load_acc
);
  logic hit;

  assign load_acc = en & rx_ev & ~rxbf;
  assign hit      = addr_hit(rx_byte, own_addr, ext_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rxbf    <= 1'b0;
      match   <= 1'b0;
      srw     <= 1'b0;
    end else if (!en) begin
      rxbf    <= 1'b0;
      match   <= 1'b0;
      srw     <= 1'b0;
    end else if (load_acc) begin
      rx_data <= rx_byte;
      rxbf    <= 1'b1;
      if (rx_is_addr) begin
        match <= hit;
        if (hit) srw <= rx_byte[0];
      end
    end else if (rx_rd) begin
      rxbf    <= 1'b0;
    end
  end

  p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_ev && !rxbf) |=> (rxbf && rx_data == $past(rx_byte)));
  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ev && rxbf) |=> $stable(rx_data));
  p_read_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_rd && rxbf) |=> !rxbf);
  p_miss_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_acc && rx_is_addr && !hit) |=> (!match && $stable(srw)));
endmodule

// File: rtl/serstat_top.sv
module serstat_top
  import serstat_pkg::*;
#(
  parameter int N_WZC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ie_i,
  input  logic              ext_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              rx_ev_i,
  input  logic              rx_is_addr_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              tx_load_ev_i,
  input  logic              ack_ev_i,
  input  logic              nak_i,
  input  logic              scl_ev_i,
  input  logic              rx_rd_i,
  input  logic              tx_wr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              irq_o
);
  localparam int WZC_POS [N_WZC] = '{B_RXIF, B_TXIF, B_SCLIF};

  logic             load_acc, rxbf, match, srw;
  logic             txbe, rxak;
  logic [N_WZC-1:0] wzc_set, wzc_clr, wzc_q;

  serstat_rxbuf u_rx (
    .clk(clk), .rst_n(rst_n), .en(en_i),
    .rx_ev(rx_ev_i), .rx_is_addr(rx_is_addr_i), .rx_byte(rx_byte_i),
    .rx_rd(rx_rd_i), .own_addr(own_addr_i), .ext_en(ext_en_i),
    .rx_data(rx_data_o), .rxbf(rxbf), .match(match), .srw(srw),
    .load_acc(load_acc)
  );

  assign wzc_set = {scl_ev_i, tx_load_ev_i, load_acc};

  for (genvar g = 0; g < N_WZC; g++) begin : g_wzc
    assign wzc_clr[g] = reg_wr_i & ~reg_wdata_i[WZC_POS[g]];
    serstat_wzc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .en(en_i),
      .set(wzc_set[g]), .clr(wzc_clr[g]), .q(wzc_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbe <= STAT_RST[B_TXBE];
      rxak <= STAT_RST[B_RXAK];
    end else if (!en_i) begin
      txbe <= STAT_RST[B_TXBE];
      rxak <= STAT_RST[B_RXAK];
    end else begin
      if (tx_load_ev_i)  txbe <= 1'b1;
      else if (tx_wr_i)  txbe <= 1'b0;
      if (ack_ev_i)      rxak <= nak_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[B_RXIF]  = wzc_q[0];
    status_o[B_TXIF]  = wzc_q[1];
    status_o[B_SCLIF] = wzc_q[2];
    status_o[B_MATCH] = match;
    status_o[B_SRW]   = srw;
    status_o[B_RXAK]  = rxak;
    status_o[B_TXBE]  = txbe;
    status_o[B_RXBF]  = rxbf;
  end

  assign irq_o = ie_i & (|wzc_q);

  p_off_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (status_o == STAT_RST));
  p_txload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tx_load_ev_i) |=> (status_o[B_TXIF] && status_o[B_TXBE]));
  p_txwr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tx_wr_i && !tx_load_ev_i) |=> !status_o[B_TXBE]);
  p_ro_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && reg_wr_i && !rx_ev_i && !ack_ev_i && !tx_load_ev_i && !tx_wr_i && !rx_rd_i)
      |=> $stable({status_o[B_MATCH], status_o[B_SRW], status_o[B_RXAK],
                   status_o[B_TXBE], status_o[B_RXBF]}));
  p_ack_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ack_ev_i) |=> (status_o[B_RXAK] == $past(nak_i)));
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_i) |-> !irq_o);
endmodule

// File: tb/serstat_top_tb.sv
module serstat_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 0, ie_i = 0, ext_en_i = 0;
  logic [6:0] own_addr_i = 7'h00;
  logic       rx_ev_i = 0, rx_is_addr_i = 0;
  logic [7:0] rx_byte_i = 8'h00;
  logic       tx_load_ev_i = 0, ack_ev_i = 0, nak_i = 0, scl_ev_i = 0;
  logic       rx_rd_i = 0, tx_wr_i = 0, reg_wr_i = 0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] status_o, rx_data_o;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;

  // expected state
  logic e_rxif, e_txif, e_match, e_srw, e_rxak, e_sclif, e_txbe, e_rxbf;
  logic [7:0] e_data;

  always #2 clk = ~clk;

  serstat_top u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ie_i(ie_i), .ext_en_i(ext_en_i),
    .own_addr_i(own_addr_i), .rx_ev_i(rx_ev_i), .rx_is_addr_i(rx_is_addr_i),
    .rx_byte_i(rx_byte_i), .tx_load_ev_i(tx_load_ev_i), .ack_ev_i(ack_ev_i),
    .nak_i(nak_i), .scl_ev_i(scl_ev_i), .rx_rd_i(rx_rd_i), .tx_wr_i(tx_wr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .status_o(status_o), .rx_data_o(rx_data_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] e_status();
    return {e_rxif, e_txif, e_match, e_srw, e_rxak, e_sclif, e_txbe, e_rxbf};
  endfunction

  // address match written from the requirement text (R8, R9)
  function automatic logic b_hit(logic [7:0] b, logic [6:0] own, logic ext);
    if (ext) return (b >> 4) == (own >> 3);
    return (b >> 1) == {1'b0, own};
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    {e_rxif, e_txif, e_match, e_srw, e_rxak, e_sclif, e_txbe, e_rxbf} = 8'h0A;
    e_data = 8'h00;
  endtask

  task automatic model_step();
    logic take, ck;
    if (!en_i) begin
      {e_rxif, e_txif, e_match, e_srw, e_rxak, e_sclif, e_txbe, e_rxbf} = 8'h0A;
      return;
    end
    take = rx_ev_i && !e_rxbf;
    ck = reg_wr_i;
    e_rxif  = take         ? 1'b1 : ((ck && !reg_wdata_i[7]) ? 1'b0 : e_rxif);
    e_txif  = tx_load_ev_i ? 1'b1 : ((ck && !reg_wdata_i[6]) ? 1'b0 : e_txif);
    e_sclif = scl_ev_i     ? 1'b1 : ((ck && !reg_wdata_i[2]) ? 1'b0 : e_sclif);
    if (take) begin
      e_data = rx_byte_i;
      e_rxbf = 1'b1;
      if (rx_is_addr_i) begin
        e_match = b_hit(rx_byte_i, own_addr_i, ext_en_i);
        if (e_match) e_srw = rx_byte_i[0];
      end
    end else if (rx_rd_i) e_rxbf = 1'b0;
    if (tx_load_ev_i) e_txbe = 1'b1;
    else if (tx_wr_i) e_txbe = 1'b0;
    if (ack_ev_i) e_rxak = nak_i;
  endtask

  task automatic idle_pulses();
    rx_ev_i = 0; rx_is_addr_i = 0; tx_load_ev_i = 0; ack_ev_i = 0;
    scl_ev_i = 0; rx_rd_i = 0; tx_wr_i = 0; reg_wr_i = 0;
  endtask

  // one cycle: predict, clock, compare at falling edge, clear pulses
  task automatic tick();
    logic [7:0] es;
    logic ei;
    model_step();
    @(posedge clk);
    @(negedge clk);
    es = e_status();
    ei = ie_i && (e_rxif || e_txif || e_sclif);
    chk(rx_data_o == e_data, "R2/R3 rx data", rx_data_o, e_data);
    chk({status_o[7], status_o[0]} == {es[7], es[0]}, "R2/R4 rx flags", status_o, es);
    chk({status_o[6], status_o[1]} == {es[6], es[1]}, "R5 tx flags", status_o, es);
    chk(status_o[5:4] == es[5:4], "R8 match/dir", status_o, es);
    chk({status_o[3], status_o[2]} == {es[3], es[2]}, "R12 ack/clock", status_o, es);
    chk(irq_o == ei, "R10 irq", {7'h0, irq_o}, {7'h0, ei});
    idle_pulses();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd24601;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset value
    chk(status_o == 8'h0A, "R1 reset status", status_o, 8'h0A);
    chk(rx_data_o == 8'h00, "R1 reset data", rx_data_o, 8'h00);
    chk(irq_o == 1'b0, "R1 reset irq", {7'h0, irq_o}, 8'h00);
    rst_n = 1'b1;
    en_i = 1; ie_i = 1;
    // R2: accept a byte
    rx_ev_i = 1; rx_byte_i = 8'h55; tick();
    chk(status_o == 8'h8B && rx_data_o == 8'h55, "R2 accept", status_o, 8'h8B);
    // R3: dropped while full
    rx_ev_i = 1; rx_byte_i = 8'hAA; rx_is_addr_i = 1; own_addr_i = 7'h55; tick();
    chk(status_o == 8'h8B && rx_data_o == 8'h55, "R3 drop", rx_data_o, 8'h55);
    // R4: read clears full
    rx_rd_i = 1; tick();
    chk(status_o == 8'h8A, "R4 read", status_o, 8'h8A);
    // R6: write ones no effect, then zeros clear
    reg_wr_i = 1; reg_wdata_i = 8'hFF; tick();
    chk(status_o == 8'h8A, "R6 write one", status_o, 8'h8A);
    reg_wr_i = 1; reg_wdata_i = 8'h00; tick();
    chk(status_o == 8'h0A, "R7 read-only kept", status_o, 8'h0A);
    // R8: full address match with direction 1
    own_addr_i = 7'h3A;
    rx_ev_i = 1; rx_is_addr_i = 1; rx_byte_i = 8'h75; tick();
    chk(status_o[5:4] == 2'b11, "R8 hit", {6'h0, status_o[5:4]}, 8'h03);
    rx_rd_i = 1; tick();
    rx_ev_i = 1; rx_is_addr_i = 1; rx_byte_i = 8'h76; tick();
    chk(status_o[5:4] == 2'b01, "R8 miss", {6'h0, status_o[5:4]}, 8'h01);
    rx_rd_i = 1; tick();
    // R9: group compare
    ext_en_i = 1; rx_ev_i = 1; rx_is_addr_i = 1; rx_byte_i = 8'h70; tick();
    chk(status_o[5:4] == 2'b10, "R9 ext hit", {6'h0, status_o[5:4]}, 8'h02);
    ext_en_i = 0; rx_rd_i = 1; tick();
    // R6: set beats clear in same cycle
    tx_load_ev_i = 1; reg_wr_i = 1; reg_wdata_i = 8'h00; tick();
    chk(status_o[6] == 1'b1, "R6 set wins", status_o, 8'h40);
    // R12 clock event and nak
    scl_ev_i = 1; ack_ev_i = 1; nak_i = 0; tick();
    chk(status_o[3:2] == 2'b01, "R12 ack/clk", {6'h0, status_o[3:2]}, 8'h01);
    // R10: gate off
    ie_i = 0; tick();
    chk(irq_o == 1'b0, "R10 gated", {7'h0, irq_o}, 8'h00);
    // R11: disabled ignores events
    en_i = 0; rx_ev_i = 1; scl_ev_i = 1; tx_load_ev_i = 1; tick();
    chk(status_o == 8'h0A, "R11 disabled", status_o, 8'h0A);
    en_i = 1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      en_i      = ($urandom % 40) != 0;
      ie_i      = ($urandom % 4) != 0;
      if (($urandom % 50) == 0) ext_en_i = $urandom;
      if (($urandom % 200) == 0) own_addr_i = $urandom;
      rx_ev_i   = ($urandom % 3) == 0;
      rx_is_addr_i = $urandom;
      if (($urandom % 2) == 0) rx_byte_i = {own_addr_i ^ (($urandom % 3 == 0) ? 7'h01 : 7'h00), 1'($urandom)};
      else rx_byte_i = $urandom;
      tx_load_ev_i = ($urandom % 6) == 0;
      tx_wr_i   = ($urandom % 5) == 0;
      ack_ev_i  = ($urandom % 6) == 0;
      nak_i     = $urandom;
      scl_ev_i  = ($urandom % 8) == 0;
      rx_rd_i   = ($urandom % 4) == 0;
      reg_wr_i  = ($urandom % 5) == 0;
      reg_wdata_i = $urandom;
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule